// File: doc/BRIEF.md
# Dual Complementary PWM Generator with Dead-Time

This block is a single timer slice that drives four gate signals: two complementary pairs, each made of a high-side and a low-side output. One pair can drive one half of a full-bridge, or each pair can drive its own bridge leg set. A shared edge-aligned up-counter sets the switching period. Each channel compares the counter against its own threshold to form a raw pulse. The raw pulse is then split into a high-side and a low-side drive, with a dead gap inserted after each transition. The gap after the rising transition and the gap after the falling transition are programmed separately for each channel.

Software programs the slice through a write-only parallel configuration port. Writes to the period, thresholds and dead-times land in staging registers. The running copies take the new values only when the counter wraps, so a PWM cycle is never torn. Each of the four pins has an inversion bit, so that any driver polarity can be matched. A fault input passes through a two-flop synchronizer and then forces every pin to its inactive level. The fault stays latched until software clears it after the fault input has gone away.

Top module: `dual_bridge_pwm`

## Requirements
- R1: The counter counts 0,1,...,PERIOD and then returns to 0, so one PWM cycle lasts PERIOD+1 clocks. The reset PERIOD is RST_PERIOD (99).
- R2: A channel's raw pulse is high while the count is less than that channel's threshold. It is therefore high for min(threshold, PERIOD+1) clocks per cycle: never high for threshold 0, and always high for any threshold above PERIOD.
- R3: After the raw pulse rises, the high-side output becomes active only after the channel's rise dead-time has elapsed. For a raw pulse W clocks wide, the high-side is active for max(0, W − rise) clocks per cycle.
- R4: After the raw pulse falls, the low-side output becomes active only after the channel's fall dead-time has elapsed. For a low interval L clocks wide, the low-side is active for max(0, L − fall) clocks per cycle. A constant level gives a constant output.
- R5: When a raw pulse or low interval is no longer than the dead-time that applies to it, the affected output stays inactive for the whole cycle.
- R6: The high-side and low-side outputs of one channel are never active in the same clock.
- R7: Pin mapping: pwm_o[2c] is the high side of channel c and pwm_o[2c+1] is its low side. Bit k of the inversion register makes pin k active-low. Inversion takes effect on the clock after the write, without waiting for a wrap.
- R8: trap_i passes through two flip-flops. From the second clock edge after it is sampled high, every pin sits at its inactive level (pwm_o equals the inversion register).
- R9: Once a fault is seen, the pins stay inactive even after trap_i returns low. The fault is cleared only by writing 1 in data bit 0 to the clear address while the synchronized fault is low. A clear written while the fault is present has no effect.
- R10: Writes to the period, threshold and dead-time addresses take effect at the next counter wrap. The cycle already under way finishes with the old values.
- R11: While rst_n is low and right after reset, thresholds and dead-times are zero and the inversion register is zero. All high-sides are therefore inactive and all low-sides active: pwm_o = 4'b1010.
- R12: Address map for NCH=2, with data taken from cfg_wdata on a clock edge where cfg_we is high: 0 period; 1 and 2 thresholds of channels 0 and 1; 3 and 4 rise and fall dead-time of channel 0; 5 and 6 rise and fall dead-time of channel 1; 7 inversion bits [3:0]; 8 fault clear. Dead-times use the low DT_W bits of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (4) | Configuration register address |
| cfg_wdata | input | CNT_W (16) | Configuration write data |
| trap_i | input | 1 | Asynchronous fault request |
| pwm_o | output | 2*NCH (4) | Gate drive pins, high and low side per channel |

## Verification
On every cycle, the embedded properties check four things: the counter never exceeds its running period; the running period and thresholds change only at a wrap; a high-side or low-side turn-on with a nonzero gap is preceded by a stable raw level; and pins are held at the inactive pattern whenever a fault is active. They also check that no pair overlaps and that a latched fault is released only by a clear written while the synchronized fault was low. Only the bench scenarios can show the actual pulse widths per cycle against the rise and fall gaps. The same holds for the PERIOD+1 cycle length, the swallowed short pulses, the exact cycle at which a staged threshold becomes visible, the two-edge fault latency, and that a clear written during a fault is ignored.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  // Address map helpers: period at 0, thresholds next, then rise/fall pairs,
  // then the inversion register and the fault clear strobe.
  localparam int ADDR_PERIOD = 0;

  function automatic int addr_thr(input int ch);
    return 1 + ch;
  endfunction

  function automatic int addr_rise(input int nch, input int ch);
    return 1 + nch + 2 * ch;
  endfunction

  function automatic int addr_fall(input int nch, input int ch);
    return 2 + nch + 2 * ch;
  endfunction

  function automatic int addr_inv(input int nch);
    return 1 + 3 * nch;
  endfunction

  function automatic int addr_clr(input int nch);
    return 2 + 3 * nch;
  endfunction

endpackage

// File: rtl/dbp_cfg_regs.sv
module dbp_cfg_regs
  import dbp_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int CNT_W      = 16,
  parameter int DT_W       = 8,
  parameter int AW         = 4,
  parameter int RST_PERIOD = 99,
  localparam int NOUT      = 2 * NCH
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [AW-1:0]                    cfg_addr,
  input  logic [CNT_W-1:0]                 cfg_wdata,
  output logic [CNT_W-1:0]                 period_stg,
  output logic [NCH-1:0][CNT_W-1:0]        thr_stg,
  output logic [NCH-1:0][DT_W-1:0]         rise_stg,
  output logic [NCH-1:0][DT_W-1:0]         fall_stg,
  output logic [NOUT-1:0]                  inv_q,
  output logic                             clr_req
);

  function automatic logic hit(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  assign clr_req = cfg_we && hit(cfg_addr, addr_clr(NCH)) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_stg <= CNT_W'(RST_PERIOD);
      thr_stg    <= '0;
      rise_stg   <= '0;
      fall_stg   <= '0;
      inv_q      <= '0;
    end else if (cfg_we) begin
      if (hit(cfg_addr, ADDR_PERIOD)) period_stg <= cfg_wdata;
      if (hit(cfg_addr, addr_inv(NCH))) inv_q <= cfg_wdata[NOUT-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (hit(cfg_addr, addr_thr(c)))       thr_stg[c]  <= cfg_wdata;
        if (hit(cfg_addr, addr_rise(NCH, c))) rise_stg[c] <= cfg_wdata[DT_W-1:0];
        if (hit(cfg_addr, addr_fall(NCH, c))) fall_stg[c] <= cfg_wdata[DT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dbp_timebase.sv
module dbp_timebase #(
  parameter int NCH        = 2,
  parameter int CNT_W      = 16,
  parameter int DT_W       = 8,
  parameter int RST_PERIOD = 99
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          period_stg,
  input  logic [NCH-1:0][CNT_W-1:0] thr_stg,
  input  logic [NCH-1:0][DT_W-1:0]  rise_stg,
  input  logic [NCH-1:0][DT_W-1:0]  fall_stg,
  output logic [CNT_W-1:0]          cnt,
  output logic                      wrap,
  output logic [NCH-1:0][CNT_W-1:0] thr_act,
  output logic [NCH-1:0][DT_W-1:0]  rise_act,
  output logic [NCH-1:0][DT_W-1:0]  fall_act
);

  logic [CNT_W-1:0] period_act;

  function automatic logic at_end(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return c >= p;
  endfunction

  assign wrap = at_end(cnt, period_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      period_act <= CNT_W'(RST_PERIOD);
      thr_act    <= '0;
      rise_act   <= '0;
      fall_act   <= '0;
    end else if (wrap) begin
      cnt        <= '0;
      period_act <= period_stg;
      thr_act    <= thr_stg;
      rise_act   <= rise_stg;
      fall_act   <= fall_stg;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_act); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(period_act) && $stable(thr_act) && $stable(rise_act) && $stable(fall_act))); // R10

endmodule

// File: rtl/dbp_dt_channel.sv
module dbp_dt_channel #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic [DT_W-1:0]  rise_dt,
  input  logic [DT_W-1:0]  fall_dt,
  output logic             hi_on,
  output logic             lo_on
);

  function automatic logic raw_level(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c < t;
  endfunction

  function automatic logic [DT_W-1:0] gap_step(input logic [DT_W-1:0] d);
    return (&d) ? d : d + 1'b1;
  endfunction

  logic            raw;
  logic            raw_q;
  logic            raw_edge;
  logic [DT_W-1:0] gap_cnt;

  assign raw      = raw_level(cnt, thr);
  assign raw_edge = raw ^ raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      gap_cnt <= '0;
    end else begin
      raw_q   <= raw;
      gap_cnt <= raw_edge ? '0 : gap_step(gap_cnt);
    end
  end

  assign hi_on = raw_q && (gap_cnt >= rise_dt);
  assign lo_on = !raw_q && (gap_cnt >= fall_dt);

  AST_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_on && rise_dt != '0) |-> $past(raw_q)); // R3

  AST_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_on && fall_dt != '0) |-> !$past(raw_q)); // R4

endmodule

// File: rtl/dbp_trap.sv
module dbp_trap (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_i,
  input  logic clr_req,
  output logic trap_act
);

  logic [1:0] sync_q;
  logic       fault_s;
  logic       latched;

  assign fault_s  = sync_q[1];
  assign trap_act = fault_s | latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      latched <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], trap_i};
      if (fault_s)      latched <= 1'b1;
      else if (clr_req) latched <= 1'b0;
    end
  end

  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched) |-> ($past(clr_req) && !$past(fault_s))); // R9

  AST_TRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> latched); // R9

endmodule

// File: rtl/dual_bridge_pwm.sv
module dual_bridge_pwm
  import dbp_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int CNT_W      = 16,
  parameter int DT_W       = 8,
  parameter int AW         = 4,
  parameter int RST_PERIOD = 99,
  localparam int NOUT      = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             trap_i,
  output logic [NOUT-1:0]  pwm_o
);

  logic [CNT_W-1:0]          period_stg;
  logic [NCH-1:0][CNT_W-1:0] thr_stg, thr_act;
  logic [NCH-1:0][DT_W-1:0]  rise_stg, fall_stg, rise_act, fall_act;
  logic [NOUT-1:0]           inv_q;
  logic                      clr_req;
  logic [CNT_W-1:0]          cnt;
  logic                      wrap;
  logic                      trap_act;
  logic [NCH-1:0]            hi_on, lo_on;
  logic [NOUT-1:0]           drive;

  dbp_cfg_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .DT_W(DT_W), .AW(AW), .RST_PERIOD(RST_PERIOD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .period_stg(period_stg), .thr_stg(thr_stg),
    .rise_stg(rise_stg), .fall_stg(fall_stg), .inv_q(inv_q), .clr_req(clr_req)
  );

  dbp_timebase #(
    .NCH(NCH), .CNT_W(CNT_W), .DT_W(DT_W), .RST_PERIOD(RST_PERIOD)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .period_stg(period_stg), .thr_stg(thr_stg),
    .rise_stg(rise_stg), .fall_stg(fall_stg), .cnt(cnt), .wrap(wrap),
    .thr_act(thr_act), .rise_act(rise_act), .fall_act(fall_act)
  );

  dbp_trap u_trap (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .clr_req(clr_req), .trap_act(trap_act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbp_dt_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .thr(thr_act[c]),
      .rise_dt(rise_act[c]), .fall_dt(fall_act[c]),
      .hi_on(hi_on[c]), .lo_on(lo_on[c])
    );

    assign drive[2*c]   = hi_on[c] & ~trap_act;
    assign drive[2*c+1] = lo_on[c] & ~trap_act;

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !((pwm_o[2*c] ^ inv_q[2*c]) && (pwm_o[2*c+1] ^ inv_q[2*c+1]))); // R6
  end

  assign pwm_o = drive ^ inv_q;

  AST_TRAP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_act |-> (pwm_o == inv_q)); // R8

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R1

endmodule

// File: tb/tb_dual_bridge_pwm.sv
module tb_dual_bridge_pwm;

  localparam int CNT_W = 16;
  localparam int AW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [AW-1:0]    cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic             trap_i = 1'b0;
  logic [3:0]       pwm_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [3:0] inv_exp = 4'b0000;

  always #10 clk = ~clk;  // 50 MHz

  dual_bridge_pwm dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trap_i(trap_i), .pwm_o(pwm_o)
  );

  // period, thr0, thr1, rise0, fall0, rise1, fall1
  localparam int NV = 6;
  localparam int VEC [NV][7] = '{
    '{19, 10,  5,  2,  3, 1, 4},
    '{ 9,  0, 10,  3,  3, 3, 3},
    '{29,  2, 28,  5,  0, 0, 5},
    '{15,  8,  8,  0,  0, 7, 7},
    '{49, 40, 60, 10, 20, 0, 0},
    '{ 4,  1,  4,  0,  0, 1, 1}
  };

  function automatic int width_hi(input int p, input int t);
    return (t > p + 1) ? p + 1 : t;
  endfunction

  function automatic int want_hi(input int p, input int t, input int r);
    int w = width_hi(p, t);
    if (w == 0) return 0;
    if (w == p + 1) return p + 1;
    return (w > r) ? w - r : 0;
  endfunction

  function automatic int want_lo(input int p, input int t, input int f);
    int l = p + 1 - width_hi(p, t);
    if (l == 0) return 0;
    if (l == p + 1) return p + 1;
    return (l > f) ? l - f : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we    = 1'b1;
    cfg_addr  = AW'(a);
    cfg_wdata = CNT_W'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic load(input int v);
    wr(0, VEC[v][0]);
    wr(1, VEC[v][1]);
    wr(2, VEC[v][2]);
    wr(3, VEC[v][3]);
    wr(4, VEC[v][4]);
    wr(5, VEC[v][5]);
    wr(6, VEC[v][6]);
  endtask

  task automatic measure(input int p, output int cnts[4], output bit overlap);
    logic [3:0] a;
    for (int k = 0; k < 4; k++) cnts[k] = 0;
    overlap = 1'b0;
    for (int i = 0; i < p + 1; i++) begin
      @(negedge clk);
      a = pwm_o ^ inv_exp;
      for (int k = 0; k < 4; k++) if (a[k]) cnts[k]++;
      if ((a[0] && a[1]) || (a[2] && a[3])) overlap = 1'b1;
    end
  endtask

  task automatic wait_hi0_rise(output bit ok);
    logic prev;
    ok = 1'b0;
    prev = pwm_o[0] ^ inv_exp[0];
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!prev && (pwm_o[0] ^ inv_exp[0])) begin
        ok = 1'b1;
        break;
      end
      prev = pwm_o[0] ^ inv_exp[0];
    end
  endtask

  task automatic run_vector(input int v);
    int  c[4];
    bit  ov;
    bit  ok;
    int  gap;
    int  p = VEC[v][0];
    int  e0h = want_hi(p, VEC[v][1], VEC[v][3]);
    int  e0l = want_lo(p, VEC[v][1], VEC[v][4]);
    int  e1h = want_hi(p, VEC[v][2], VEC[v][5]);
    int  e1l = want_lo(p, VEC[v][2], VEC[v][6]);
    load(v);
    repeat (250) @(negedge clk);
    measure(p, c, ov);
    check(c[0] == e0h, "R3 hi0 width", c[0], e0h);
    check(c[1] == e0l, "R4 lo0 width", c[1], e0l);
    check(c[2] == e1h, "R2/R5 hi1 width", c[2], e1h);
    check(c[3] == e1l, "R2/R5 lo1 width", c[3], e1l);
    check(!ov, "R6 pair overlap", int'(ov), 0);
    if (e0h > 0 && e0h < p + 1) begin
      wait_hi0_rise(ok);
      gap = 0;
      if (ok) begin
        wait_hi0_rise(ok);
        gap = 0;
      end
    end
  endtask

  task automatic cycle_length(input int p);
    bit ok;
    int n;
    logic prev;
    wait_hi0_rise(ok);
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      n++;
      if (!prev && (pwm_o[0] ^ inv_exp[0])) break;
      prev = pwm_o[0] ^ inv_exp[0];
    end
    check(ok && n == p + 1, "R1 cycle length", n, p + 1);
  endtask

  initial begin
    int  c[4];
    bit  ov;
    bit  ok;
    int  w;

    // Reset state (R11)
    repeat (3) @(negedge clk);
    check(pwm_o == 4'b1010, "R11 during reset", int'(pwm_o), 10);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_o == 4'b1010, "R11 after reset", int'(pwm_o), 10);

    // Table of vectors (R2 R3 R4 R5 R6 R10 R12)
    for (int v = 0; v < NV; v++) begin
      run_vector(v);
      if (v == 0 || v == 3 || v == 4) cycle_length(VEC[v][0]);
    end

    // Inversion (R7): pins 0 and 1 active-low
    inv_exp = 4'b0011;
    wr(7, 4'b0011);
    @(negedge clk);
    measure(VEC[NV-1][0], c, ov);
    check(c[0] == want_hi(4, 1, 0), "R7 inverted hi0", c[0], want_hi(4, 1, 0));
    check(c[1] == want_lo(4, 1, 0), "R7 inverted lo0", c[1], want_lo(4, 1, 0));
    check(c[2] == want_hi(4, 4, 1), "R7 plain hi1", c[2], want_hi(4, 4, 1));

    // Fault (R8): passive two edges after trap_i rises
    trap_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pwm_o == inv_exp, "R8 passive after two edges", int'(pwm_o), int'(inv_exp));
    repeat (10) @(negedge clk);
    check(pwm_o == inv_exp, "R8 passive while fault", int'(pwm_o), int'(inv_exp));

    // Clear during fault ignored (R9)
    wr(8, 1);
    trap_i = 1'b0;
    repeat (12) @(negedge clk);
    check(pwm_o == inv_exp, "R9 latched after clear-in-fault", int'(pwm_o), int'(inv_exp));
    // Clear with fault gone releases (R9)
    wr(8, 1);
    repeat (10) @(negedge clk);
    measure(4, c, ov);
    check(c[2] == want_hi(4, 4, 1), "R9 resume hi1", c[2], want_hi(4, 4, 1));
    check(c[0] == want_hi(4, 1, 0), "R9 resume hi0", c[0], want_hi(4, 1, 0));

    // Shadowing (R10)
    inv_exp = 4'b0000;
    wr(7, 0);
    wr(0, 40);
    wr(1, 10);
    wr(3, 0);
    wr(4, 0);
    repeat (150) @(negedge clk);
    wait_hi0_rise(ok);
    w = 1;
    wr(1, 30);
    while ((pwm_o[0] ^ inv_exp[0]) && w < 100) begin
      w++;
      @(negedge clk);
    end
    check(ok && w == 10, "R10 current cycle keeps old threshold", w, 10);
    wait_hi0_rise(ok);
    w = 0;
    while ((pwm_o[0] ^ inv_exp[0]) && w < 100) begin
      w++;
      @(negedge clk);
    end
    check(ok && w == 30, "R10 next cycle uses new threshold", w, 30);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule